// File: doc/BRIEF.md
# Two-Tier Fair Output Arbiter for a Packet Switch

This block decides which source port of a packet switch may drive each output port. Every source presents a request, a mask naming the output ports that may carry its packet, and one priority bit. For each output that is free and ready, the arbiter picks one requester and connects it for the whole packet. The connection lasts until the source reports that its end-of-packet character has passed.

When several sources compete for one output, high-priority requests are served first. Among requests of the same priority, each output keeps its own round-robin pointer, so every source gets equal turns. A source whose mask names more than one port is given a free, ready port from that group. Outputs are allocated in ascending index order inside one clock, so the lowest-numbered port the source can still win is the one it gets. Grants are registered: a request seen at a clock edge is granted at that edge and shows on the outputs after it.

Top module: `prio_fair_arbiter`

## Requirements
- R1: After reset no source holds a grant.
- R2: A requesting source whose mask includes a free, ready output is granted at the first clock edge that samples the request. The granted port index on `grant_port_o` (bit field `s*DW +: DW` for source s) is a port whose bit is set in that source's mask, bit `s*NDST + p` of `dest_mask_i`.
- R3: A grant and its port index stay unchanged until the edge that samples `pkt_done_i` high for that source. The grant drops at that edge, and the freed port can be granted again at the next edge.
- R4: No two sources are granted the same output port at the same time.
- R5: If a high-priority source (`hi_prio_i` = 1) and a low-priority source both compete for the same free port, the high-priority source is granted, whatever the round-robin state.
- R6: Within one priority level, each output grants the first requester at or after the source following its last winner in that level, wrapping around. After reset the pointers start at source 0.
- R7: A source whose mask names several ports receives the lowest-numbered free, ready port in its mask that was not won in the same cycle by another source. Outputs are decided from port 0 upward.
- R8: An output whose `port_ready_i` bit is low is not granted. A request for it waits until the bit is high.
- R9: `pkt_done_i` for a source that holds no grant has no effect. A source that already holds a grant is not re-arbitrated, and changes to its mask do not move its port.
- R10: A request whose masked ports are all busy waits, ungranted, until one is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NSRC | Per-source request for an output |
| dest_mask_i | input | NSRC*NDST | Per-source destination port mask; bit s*NDST+p allows port p for source s |
| hi_prio_i | input | NSRC | Per-source priority: 1 high, 0 low |
| pkt_done_i | input | NSRC | Per-source end-of-packet passed; releases the held port |
| port_ready_i | input | NDST | Per-output readiness to accept a new packet |
| grant_o | output | NSRC | Per-source grant, held for the whole packet |
| grant_port_o | output | NSRC*DW | Per-source selected output index, valid while granted |

## Verification
The assertions assume the inputs are known and stable around each rising edge, and that reset is applied before the first request. They do not assume that sources behave well: masks, priority bits and stray `pkt_done_i` pulses may take any value. The directed stimulus changes inputs only one time unit after an edge, always resets before each scenario so pointer state is known, and raises `pkt_done_i` both for granted and for idle sources. This covers release and the "no effect" case. The priority and lowest-port checks compare the outputs at an edge with the request, mask, readiness and ownership registered in the checker one cycle earlier. For that reason they depend only on the block's ports.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

    // Widest source vector the ring scan accepts.
    localparam int MAX_SRC = 32;

    // First set bit of cand[0..n-1], scanning circularly from start.
    // Returns -1 when no bit is set.
    function automatic int ring_first(input logic [MAX_SRC-1:0] cand,
                                      input int start, input int n);
        int hit;
        hit = -1;
        for (int k = n - 1; k >= 0; k--) begin
            int p;
            p = (start + k) % n;
            if (cand[p]) hit = p;
        end
        return hit;
    endfunction

endpackage

// File: rtl/prio_fair_arbiter.sv
module prio_fair_arbiter #(
    parameter int NSRC = 4,
    parameter int NDST = 4,
    localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int DW = (NDST > 1) ? $clog2(NDST) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      req_i,
    input  logic [NSRC*NDST-1:0] dest_mask_i,
    input  logic [NSRC-1:0]      hi_prio_i,
    input  logic [NSRC-1:0]      pkt_done_i,
    input  logic [NDST-1:0]      port_ready_i,
    output logic [NSRC-1:0]      grant_o,
    output logic [NSRC*DW-1:0]   grant_port_o
);
    import prio_arb_pkg::*;

    typedef struct packed {
        logic [NDST-1:0]          busy;    // output currently owned
        logic [NDST-1:0][SW-1:0]  rr_hi;   // next-first source, high tier
        logic [NDST-1:0][SW-1:0]  rr_lo;   // next-first source, low tier
        logic [NSRC-1:0]          gnt;     // source holds an output
        logic [NSRC-1:0][DW-1:0]  gport;   // output held by each source
    } arb_state_t;

    arb_state_t s_d, s_q;

    logic [NSRC-1:0][NDST-1:0] mask_w;
    assign mask_w = dest_mask_i;

    always_comb begin
        logic [NSRC-1:0]    taken;
        logic [NSRC-1:0]    hi_c;
        logic [NSRC-1:0]    lo_c;
        logic [MAX_SRC-1:0] ext_hi;
        logic [MAX_SRC-1:0] ext_lo;
        int                 w_hi;
        int                 w_lo;
        int                 win;

        s_d   = s_q;
        taken = '0;

        // Release: end of packet frees the held output after this edge.
        for (int s = 0; s < NSRC; s++) begin
            if (s_q.gnt[s] && pkt_done_i[s]) begin
                s_d.gnt[s]             = 1'b0;
                s_d.busy[s_q.gport[s]] = 1'b0;
            end
        end

        // Allocation: outputs decided in ascending order; a source wins at most one.
        for (int d = 0; d < NDST; d++) begin
            hi_c = '0;
            lo_c = '0;
            if (!s_q.busy[d] && port_ready_i[d]) begin
                for (int s = 0; s < NSRC; s++) begin
                    if (req_i[s] && !s_q.gnt[s] && mask_w[s][d] && !taken[s]) begin
                        if (hi_prio_i[s]) hi_c[s] = 1'b1;
                        else              lo_c[s] = 1'b1;
                    end
                end
            end
            ext_hi = '0;
            ext_lo = '0;
            ext_hi[NSRC-1:0] = hi_c;
            ext_lo[NSRC-1:0] = lo_c;
            w_hi = ring_first(ext_hi, int'(s_q.rr_hi[d]), NSRC);
            w_lo = ring_first(ext_lo, int'(s_q.rr_lo[d]), NSRC);
            win  = -1;
            if (w_hi >= 0) begin
                win           = w_hi;
                s_d.rr_hi[d]  = SW'((w_hi + 1) % NSRC);
            end else if (w_lo >= 0) begin
                win           = w_lo;
                s_d.rr_lo[d]  = SW'((w_lo + 1) % NSRC);
            end
            if (win >= 0) begin
                taken[win]     = 1'b1;
                s_d.gnt[win]   = 1'b1;
                s_d.gport[win] = DW'(d);
                s_d.busy[d]    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign grant_o      = s_q.gnt;
    assign grant_port_o = s_q.gport;

endmodule

// File: rtl/prio_arb_checker.sv
module prio_arb_checker #(
    parameter int NSRC = 4,
    parameter int NDST = 4,
    localparam int DW = (NDST > 1) ? $clog2(NDST) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NSRC-1:0]      req_i,
    input logic [NSRC*NDST-1:0] dest_mask_i,
    input logic [NSRC-1:0]      hi_prio_i,
    input logic [NSRC-1:0]      pkt_done_i,
    input logic [NDST-1:0]      port_ready_i,
    input logic [NSRC-1:0]      grant_o,
    input logic [NSRC*DW-1:0]   grant_port_o
);
    logic [NSRC-1:0]      req_q, hi_q, gnt_q;
    logic [NSRC*NDST-1:0] mask_q;
    logic [NDST-1:0]      ready_q, own_q, own_now;
    logic [NSRC-1:0]      in_mask, rdy_ok, lower_skip, hi_skipped;
    logic                 dup;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0; hi_q <= '0; gnt_q <= '0;
            mask_q <= '0; ready_q <= '0; own_q <= '0;
        end else begin
            req_q <= req_i; hi_q <= hi_prio_i; gnt_q <= grant_o;
            mask_q <= dest_mask_i; ready_q <= port_ready_i; own_q <= own_now;
        end
    end

    always_comb begin
        own_now = '0;
        dup     = 1'b0;
        for (int s = 0; s < NSRC; s++) begin
            if (grant_o[s]) own_now[grant_port_o[s*DW +: DW]] = 1'b1;
            for (int t = s + 1; t < NSRC; t++) begin
                if (grant_o[s] && grant_o[t] &&
                    grant_port_o[s*DW +: DW] == grant_port_o[t*DW +: DW]) dup = 1'b1;
            end
        end
    end

    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            int p;
            p = int'(grant_port_o[s*DW +: DW]);
            in_mask[s]    = mask_q[s*NDST + p];
            rdy_ok[s]     = ready_q[p];
            lower_skip[s] = 1'b0;
            hi_skipped[s] = 1'b0;
            for (int q = 0; q < NDST; q++) begin
                if (q < p && mask_q[s*NDST + q] && ready_q[q] && !own_q[q] && !own_now[q])
                    lower_skip[s] = 1'b1;
            end
            for (int t = 0; t < NSRC; t++) begin
                if (t != s && !hi_q[s] && hi_q[t] && req_q[t] && !gnt_q[t] &&
                    mask_q[t*NDST + p] && !grant_o[t])
                    hi_skipped[s] = 1'b1;
            end
        end
    end

    // R4: one owner per output
    p_unique_owner_r4: assert property (@(posedge clk) disable iff (!rst_n) !dup);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        // R2: new grant follows a request and lands inside the mask
        p_grant_in_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant_o[s]) |-> (req_q[s] && in_mask[s]));
        // R8: new grant only on a port that was ready
        p_port_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant_o[s]) |-> rdy_ok[s]);
        // R3: grant and port held until end of packet
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_o[s] && !pkt_done_i[s]) |=>
            (grant_o[s] && $stable(grant_port_o[s*DW +: DW])));
        // R3: end of packet releases the grant
        p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_o[s] && pkt_done_i[s]) |=> !grant_o[s]);
        // R7: no lower free, ready port of the mask left idle
        p_lowest_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant_o[s]) |-> !lower_skip[s]);
        // R5: a low-priority win never leaves a waiting high-priority rival unserved
        p_hi_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(grant_o[s]) |-> !hi_skipped[s]);
    end

endmodule

bind prio_fair_arbiter prio_arb_checker #(.NSRC(NSRC), .NDST(NDST)) u_chk (.*);

// File: tb/tb_prio_fair_arbiter.sv
module tb_prio_fair_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 4;
    localparam int NDST = 4;
    localparam int DW   = 2;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NSRC-1:0]      req_i, hi_prio_i, pkt_done_i;
    logic [NSRC*NDST-1:0] dest_mask_i;
    logic [NDST-1:0]      port_ready_i;
    logic [NSRC-1:0]      grant_o;
    logic [NSRC*DW-1:0]   grant_port_o;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_fair_arbiter #(.NSRC(NSRC), .NDST(NDST)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .dest_mask_i(dest_mask_i),
        .hi_prio_i(hi_prio_i), .pkt_done_i(pkt_done_i), .port_ready_i(port_ready_i),
        .grant_o(grant_o), .grant_port_o(grant_port_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_src(input int s, input logic r, input logic [NDST-1:0] m, input logic h);
        req_i[s] = r;
        dest_mask_i[s*NDST +: NDST] = m;
        hi_prio_i[s] = h;
    endtask

    task automatic check_grant(input int s, input logic eg, input int ep, input string tag);
        int ap;
        ap = int'(grant_port_o[s*DW +: DW]);
        tests++;
        if (grant_o[s] !== eg || (eg && ap != ep)) begin
            fails++;
            $display("FAIL %s: src%0d grant=%0b port=%0d, expected grant=%0b port=%0d",
                     tag, s, grant_o[s], ap, eg, ep);
        end
    endtask

    task automatic check_unique();
        logic clash;
        clash = 1'b0;
        for (int s = 0; s < NSRC; s++)
            for (int t = s + 1; t < NSRC; t++)
                if (grant_o[s] && grant_o[t] &&
                    grant_port_o[s*DW +: DW] == grant_port_o[t*DW +: DW]) clash = 1'b1;
        tests++;
        if (clash) begin
            fails++;
            $display("FAIL R4: shared port, grants=%b ports=%h, expected no clash", grant_o, grant_port_o);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_i = '0; hi_prio_i = '0; pkt_done_i = '0;
        dest_mask_i = '0; port_ready_i = '1;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        tests++;
        if (grant_o !== '0) begin
            fails++;
            $display("FAIL R1: grant_o=%b, expected 0", grant_o);
        end
    endtask

    task automatic t_hold_release();
        do_reset();
        set_src(1, 1'b1, 4'b0100, 1'b0);
        check_grant(1, 1'b0, 0, "R2 not before edge");
        tick();
        check_grant(1, 1'b1, 2, "R2");
        set_src(0, 1'b1, 4'b0100, 1'b0);
        pkt_done_i[2] = 1'b1;                  // idle source: R9
        tick();
        pkt_done_i[2] = 1'b0;
        check_grant(1, 1'b1, 2, "R9 stray done");
        check_grant(0, 1'b0, 0, "R3 waits");
        dest_mask_i[1*NDST +: NDST] = 4'b0001; // mask change while held: R9
        tick();
        check_grant(1, 1'b1, 2, "R9 mask change");
        pkt_done_i[1] = 1'b1;
        req_i[1] = 1'b0;
        tick();
        pkt_done_i[1] = 1'b0;
        check_grant(1, 1'b0, 0, "R3 release");
        check_grant(0, 1'b0, 0, "R3 not same edge");
        tick();
        check_grant(0, 1'b1, 2, "R3 reuse");
        check_unique();
    endtask

    task automatic t_priority();
        do_reset();
        set_src(0, 1'b1, 4'b0001, 1'b0);
        set_src(3, 1'b1, 4'b0001, 1'b1);
        tick();
        check_grant(3, 1'b1, 0, "R5 high wins");
        check_grant(0, 1'b0, 0, "R5 low waits");
        pkt_done_i[3] = 1'b1;
        req_i[3] = 1'b0;
        tick();
        pkt_done_i[3] = 1'b0;
        tick();
        check_grant(0, 1'b1, 0, "R5 low after high");
    endtask

    task automatic t_round_robin();
        do_reset();
        for (int s = 0; s < 3; s++) set_src(s, 1'b1, 4'b0001, 1'b0);
        tick();
        check_grant(0, 1'b1, 0, "R6 first");
        pkt_done_i[0] = 1'b1; req_i[0] = 1'b0;
        tick();
        pkt_done_i[0] = 1'b0;
        tick();
        check_grant(1, 1'b1, 0, "R6 second");
        req_i[0] = 1'b1;
        pkt_done_i[1] = 1'b1; req_i[1] = 1'b0;
        tick();
        pkt_done_i[1] = 1'b0;
        tick();
        check_grant(2, 1'b1, 0, "R6 third");
        check_grant(0, 1'b0, 0, "R6 skip wrap");
        pkt_done_i[2] = 1'b1; req_i[2] = 1'b0;
        tick();
        pkt_done_i[2] = 1'b0;
        tick();
        check_grant(0, 1'b1, 0, "R6 wrap");
    endtask

    task automatic t_group();
        do_reset();
        set_src(0, 1'b1, 4'b0001, 1'b0);
        set_src(1, 1'b1, 4'b0011, 1'b0);
        tick();
        check_grant(0, 1'b1, 0, "R7 port0");
        check_grant(1, 1'b1, 1, "R7 next free");
        set_src(2, 1'b1, 4'b0111, 1'b0);
        tick();
        check_grant(2, 1'b1, 2, "R7 skip busy");
        check_unique();
    endtask

    task automatic t_ready_busy();
        do_reset();
        port_ready_i = 4'b1110;
        set_src(0, 1'b1, 4'b0011, 1'b0);
        set_src(1, 1'b1, 4'b0001, 1'b0);
        tick();
        check_grant(0, 1'b1, 1, "R8 avoid unready");
        tick();
        check_grant(1, 1'b0, 0, "R8 wait");
        port_ready_i = 4'b1111;
        tick();
        check_grant(1, 1'b1, 0, "R8 ready");
        set_src(2, 1'b1, 4'b0011, 1'b0);
        tick();
        tick();
        check_grant(2, 1'b0, 0, "R10 all busy");
        pkt_done_i[0] = 1'b1; req_i[0] = 1'b0;
        tick();
        pkt_done_i[0] = 1'b0;
        tick();
        check_grant(2, 1'b1, 1, "R10 after release");
        check_unique();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_hold_release();
        t_priority();
        t_round_robin();
        t_group();
        t_ready_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule